// File: doc/BRIEF.md
# Zero-Suppressed Channel Event Assembler

This block forms one event from a sixteen-channel acquisition module that is triggered globally. A free-running stamp counter advances once per clock. When a trigger is taken, the counter value at that edge becomes the event's time tag. The block then drives the front end through a gate window and a single convert strobe, and captures the twelve-bit result of every channel at the same moment. It keeps only the channels whose result is strictly above their own threshold. Behind a header, it writes one word for each kept channel into a one-event buffer.

The staged event waits until the trigger controller issues a commit or a discard. A committed event is streamed out over a valid/ready port, header first. A discarded event is dropped without any output. A trigger is acknowledged only when the block is idle and the minimum conversion spacing has passed. A trigger with no acknowledge tells the controller that this module did not take the event.

The control states are IDLE, GATE, SAMPLE, PACK, HEADER, HOLD and SEND. The transitions are:
- IDLE to GATE on a taken trigger.
- GATE to SAMPLE when the window count runs out.
- SAMPLE to PACK, always.
- PACK to HEADER after the last channel.
- HEADER to HOLD, always.
- HOLD to IDLE on discard, or HOLD to SEND on commit.
- SEND to IDLE once the last word has been handed off.

Top module: `zs_event_asm`

## Requirements
- R1: The stamp counter is 0 after reset and adds 1 on every clock. The header carries the counter value seen at the clock edge that takes the trigger, in bits [39:0].
- R2: A trigger is taken only in IDLE and only when at least MIN_GAP (default 100) clocks have passed since the previous taken trigger. `trig_ack_o` is high for exactly the one cycle after the taking edge.
- R3: With `integ_en_i` high, `gate_o` is high for max(`gate_width_i`,1) cycles, starting in the cycle after the taking edge. `sample_o` is then high for exactly one cycle, and it never overlaps `gate_o`.
- R4: With `integ_en_i` low, `gate_o` stays low, and `sample_o` keeps the same delay, so the gate width acts as a trigger-to-sample delay.
- R5: `adc_data_i` is captured at the edge that ends the `sample_o` cycle. Channel c (bits [12c+11:12c]) is kept only if its value is strictly greater than `thresh_i` bits [12c+11:12c]. A value equal to the threshold is suppressed.
- R6: The event is a header word followed by one word per kept channel, in ascending channel order. The header has bit 45 = 1, bits [44:40] = the kept count and bits [39:0] = the stamp. A channel word has bit 45 = 0, bits [44:16] = 0, bits [15:12] = the channel index and bits [11:0] = the value.
- R7: `held_o` rises NCH+2 cycles after the `sample_o` cycle, which is cycle T+W+NCH+3 for a trigger taken at edge count T with gate length W. It stays high until a commit or discard is taken.
- R8: A commit taken in HOLD raises `rd_valid_o` in the next cycle. The words are handed off one per cycle in which `rd_valid_o` and `rd_ready_i` are both high, and `rd_data_o` stays unchanged while the port is stalled. After the last word, `rd_valid_o` drops and the block returns to IDLE.
- R9: A discard taken in HOLD drops the event, and `rd_valid_o` never rises for it. A discard and a commit in the same cycle count as a discard.
- R10: A trigger in any state other than IDLE is not acknowledged and does not disturb the event in progress.
- R11: `accept_i` and `clear_i` have no effect outside HOLD.
- R12: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one stamp tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Global trigger request |
| integ_en_i | input | 1 | 1 = integrate during the gate, 0 = gate is only a delay |
| gate_width_i | input | GW (8) | Gate length in clocks (0 is treated as 1) |
| thresh_i | input | NCH*VW (192) | Per-channel suppression thresholds |
| adc_data_i | input | NCH*VW (192) | Per-channel conversion results |
| accept_i | input | 1 | Commit the staged event |
| clear_i | input | 1 | Discard the staged event |
| rd_ready_i | input | 1 | Reader can take a word |
| trig_ack_o | output | 1 | Trigger taken (one-cycle pulse) |
| gate_o | output | 1 | Integration gate to the front end |
| sample_o | output | 1 | Convert strobe |
| held_o | output | 1 | Event staged, awaiting decision |
| rd_valid_o | output | 1 | Output word valid |
| rd_data_o | output | 46 | Output event word |

## Verification
Every result is due at a fixed cycle counted from the clock edge that takes the trigger:
- the acknowledge one cycle after that edge;
- the gate for W cycles after that;
- the strobe in the cycle after the gate;
- the hold flag NCH+2 cycles after the strobe;
- the first output word in the cycle after a commit.

The bench keeps its own edge counter alongside the design. It notes the count at which it raises each trigger, and from that count it computes every expected level for every clock. It compares at the falling edge, after all registers have settled. The output words are checked only on handshake cycles, against a queue built from the stimulus values. Triggers that should be refused leave the expected schedule unchanged, so any stray acknowledge or gate shows up as a mismatch.

// File: rtl/zs_asm_pkg.sv
package zs_asm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_SAMPLE,
        ST_PACK,
        ST_HEADER,
        ST_HOLD,
        ST_SEND
    } asm_state_e;

endpackage

// File: rtl/zs_stamp_ctr.sv
module zs_stamp_ctr #(
    parameter int TSW = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [TSW-1:0] stamp_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stamp_o <= '0;
        else        stamp_o <= stamp_o + 1'b1;
    end

endmodule

// File: rtl/zs_thresh_filt.sv
module zs_thresh_filt #(
    parameter int NCH = 16,
    parameter int VW  = 12
) (
    input  logic [NCH*VW-1:0] vals_i,
    input  logic [NCH*VW-1:0] thr_i,
    output logic [NCH-1:0]    keep_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        assign keep_o[c] = vals_i[c*VW +: VW] > thr_i[c*VW +: VW];
    end

endmodule

// File: rtl/zs_event_buf.sv
module zs_event_buf #(
    parameter int DEPTH = 17,
    parameter int WW    = 46,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [WW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [WW-1:0] rdata_o
);

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/zs_event_asm.sv
module zs_event_asm
    import zs_asm_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int VW      = 12,
    parameter int TSW     = 40,
    parameter int GW      = 8,
    parameter int MIN_GAP = 100,
    localparam int WW     = 1 + $clog2(NCH + 1) + TSW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              integ_en_i,
    input  logic [GW-1:0]     gate_width_i,
    input  logic [NCH*VW-1:0] thresh_i,
    input  logic [NCH*VW-1:0] adc_data_i,
    input  logic              accept_i,
    input  logic              clear_i,
    input  logic              rd_ready_i,
    output logic              trig_ack_o,
    output logic              gate_o,
    output logic              sample_o,
    output logic              held_o,
    output logic              rd_valid_o,
    output logic [WW-1:0]     rd_data_o
);

    localparam int CNTW = $clog2(NCH + 1);
    localparam int IW   = $clog2(NCH);
    localparam int GAPW = $clog2(MIN_GAP + 1);
    localparam int PADW = WW - 1 - IW - VW;

    asm_state_e state, state_nx;

    logic [TSW-1:0]    ts, stamp_q;
    logic [GW-1:0]     cnt;
    logic [GAPW-1:0]   gap;
    logic              integ_q, ack_q;
    logic [NCH*VW-1:0] vals_q;
    logic [NCH-1:0]    keep_now, keep_q;
    logic [IW-1:0]     idx;
    logic [CNTW-1:0]   nkeep, rptr;
    logic              trig_take;

    logic              buf_we;
    logic [CNTW-1:0]   buf_waddr;
    logic [WW-1:0]     buf_wdata;

    zs_stamp_ctr #(.TSW(TSW)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .stamp_o (ts)
    );

    zs_thresh_filt #(.NCH(NCH), .VW(VW)) u_filt (
        .vals_i (adc_data_i),
        .thr_i  (thresh_i),
        .keep_o (keep_now)
    );

    zs_event_buf #(.DEPTH(NCH + 1), .WW(WW)) u_buf (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (buf_waddr),
        .wdata_i (buf_wdata),
        .raddr_i (rptr),
        .rdata_o (rd_data_o)
    );

    assign trig_take = (state == ST_IDLE) && trig_i && (gap == '0);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (trig_take) state_nx = ST_GATE;
            ST_GATE:   if (cnt == '0) state_nx = ST_SAMPLE;
            ST_SAMPLE: state_nx = ST_PACK;
            ST_PACK:   if (idx == IW'(NCH - 1)) state_nx = ST_HEADER;
            ST_HEADER: state_nx = ST_HOLD;
            ST_HOLD: begin
                if (clear_i)       state_nx = ST_IDLE;
                else if (accept_i) state_nx = ST_SEND;
            end
            ST_SEND:   if (rd_ready_i && (rptr == nkeep)) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp_q <= '0;
            cnt     <= '0;
            gap     <= '0;
            integ_q <= 1'b0;
            ack_q   <= 1'b0;
            vals_q  <= '0;
            keep_q  <= '0;
            idx     <= '0;
            nkeep   <= '0;
            rptr    <= '0;
        end else begin
            ack_q <= trig_take;
            if (trig_take) begin
                stamp_q <= ts;
                integ_q <= integ_en_i;
                cnt     <= (gate_width_i == '0) ? '0 : gate_width_i - 1'b1;
                idx     <= '0;
                nkeep   <= '0;
                gap     <= GAPW'(MIN_GAP - 1);
            end else if (gap != '0) begin
                gap <= gap - 1'b1;
            end
            case (state)
                ST_GATE:   if (cnt != '0) cnt <= cnt - 1'b1;
                ST_SAMPLE: begin
                    vals_q <= adc_data_i;
                    keep_q <= keep_now;
                end
                ST_PACK: begin
                    idx <= idx + 1'b1;
                    if (keep_q[idx]) nkeep <= nkeep + 1'b1;
                end
                ST_HOLD:   rptr <= '0;
                ST_SEND:   if (rd_ready_i) rptr <= rptr + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        trig_ack_o = ack_q;
        gate_o     = 1'b0;
        sample_o   = 1'b0;
        held_o     = 1'b0;
        rd_valid_o = 1'b0;
        buf_we     = 1'b0;
        buf_waddr  = nkeep + 1'b1;
        buf_wdata  = {1'b0, {PADW{1'b0}}, idx, vals_q[idx*VW +: VW]};
        unique case (state)
            ST_IDLE:   ;
            ST_GATE:   gate_o = integ_q;
            ST_SAMPLE: sample_o = 1'b1;
            ST_PACK:   buf_we = keep_q[idx];
            ST_HEADER: begin
                buf_we    = 1'b1;
                buf_waddr = '0;
                buf_wdata = {1'b1, nkeep, stamp_q};
            end
            ST_HOLD:   held_o = 1'b1;
            ST_SEND:   rd_valid_o = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/zs_event_asm_chk.sv
module zs_event_asm_chk #(
    parameter int MIN_GAP = 100,
    parameter int WW      = 46
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig_ack_o,
    input logic          gate_o,
    input logic          sample_o,
    input logic          held_o,
    input logic          rd_valid_o,
    input logic          rd_ready_i,
    input logic [WW-1:0] rd_data_o
);

    localparam int SW = $clog2(MIN_GAP + 1);

    logic [SW-1:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   since <= SW'(MIN_GAP);
        else if (trig_ack_o)          since <= SW'(1);
        else if (since < SW'(MIN_GAP)) since <= since + 1'b1;
    end

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ack_o |=> !trig_ack_o);

    // R2
    ack_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ack_o |-> (since >= SW'(MIN_GAP)));

    // R3
    sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);

    // R3
    gate_sample_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o && sample_o));

    // R7
    hold_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(held_o && rd_valid_o));

    // R8
    rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

    // R6
    header_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> rd_data_o[WW-1]);

endmodule

bind zs_event_asm zs_event_asm_chk #(.MIN_GAP(MIN_GAP), .WW(WW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_ack_o (trig_ack_o),
    .gate_o     (gate_o),
    .sample_o   (sample_o),
    .held_o     (held_o),
    .rd_valid_o (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .rd_data_o  (rd_data_o)
);

// File: tb/zs_event_asm_bench.sv
module zs_event_asm_bench;

    localparam int NCH = 16, VW = 12, TSW = 40, GW = 8, MIN_GAP = 100, WW = 46;
    localparam int BIG = 1 << 30;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              trig_i = 1'b0, integ_en_i = 1'b0;
    logic [GW-1:0]     gate_width_i = '0;
    logic [NCH*VW-1:0] thresh_i, adc_data_i;
    logic              accept_i = 1'b0, clear_i = 1'b0, rd_ready_i = 1'b0;
    logic              trig_ack_o, gate_o, sample_o, held_o, rd_valid_o;
    logic [WW-1:0]     rd_data_o;

    logic [VW-1:0] adc_v [NCH];
    logic [VW-1:0] thr_v [NCH];

    int tests = 0, fails = 0, cyc = 0;
    int acc_m = -100000, w_m = 1, dec_c = -1;
    bit integ_m = 1'b0, reading = 1'b0;
    logic [WW-1:0] expq [$];

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            adc_data_i[c*VW +: VW] = adc_v[c];
            thresh_i[c*VW +: VW]   = thr_v[c];
        end
    end

    zs_event_asm u_zs_event_asm (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .integ_en_i(integ_en_i),
        .gate_width_i(gate_width_i), .thresh_i(thresh_i), .adc_data_i(adc_data_i),
        .accept_i(accept_i), .clear_i(clear_i), .rd_ready_i(rd_ready_i),
        .trig_ack_o(trig_ack_o), .gate_o(gate_o), .sample_o(sample_o),
        .held_o(held_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 trig_ack_o", 64'(trig_ack_o), 64'(cyc == acc_m + 1));
            chk("R3/R4 gate_o", 64'(gate_o),
                64'(integ_m && cyc >= acc_m + 1 && cyc <= acc_m + w_m));
            chk("R3 sample_o", 64'(sample_o), 64'(cyc == acc_m + w_m + 1));
            chk("R7 held_o", 64'(held_o),
                64'(cyc >= acc_m + w_m + NCH + 3 && cyc <= dec_c));
            if (!reading) chk("R9 rd_valid_o idle", 64'(rd_valid_o), 64'(0));
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic fire(input bit expect_ack);
        int n;
        trig_i = 1'b1;
        if (expect_ack) begin
            acc_m   = cyc;
            w_m     = (gate_width_i == '0) ? 1 : int'(gate_width_i);
            integ_m = integ_en_i;
            dec_c   = BIG;
            expq.delete();
            n = 0;
            for (int c = 0; c < NCH; c++) if (adc_v[c] > thr_v[c]) n++;
            expq.push_back({1'b1, 5'(n), 40'(acc_m)});
            for (int c = 0; c < NCH; c++)
                if (adc_v[c] > thr_v[c]) expq.push_back({1'b0, 29'b0, 4'(c), adc_v[c]});
        end
        tick();
        trig_i = 1'b0;
    endtask

    task automatic wait_held();
        for (int k = 0; k < 400 && !held_o; k++) tick();
        chk("R7 held_o first cycle", 64'(cyc), 64'(acc_m + w_m + NCH + 3));
    endtask

    task automatic decide(input bit acc, input bit clr);
        accept_i = acc;
        clear_i  = clr;
        dec_c    = cyc;
        tick();
        accept_i = 1'b0;
        clear_i  = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) tick();
    endtask

    task automatic read_event(input int pat);
        int n = 0;
        bit first = 1'b1, hdr = 1'b1;
        reading = 1'b1;
        while (expq.size() > 0 && n < 200) begin
            rd_ready_i = (pat == 0) ? 1'b1 : ((n % 3) != 0);
            @(negedge clk);
            if (first) begin
                chk("R8 rd_valid_o after accept", 64'(rd_valid_o), 64'(1));
                first = 1'b0;
            end
            if (rd_valid_o && rd_ready_i) begin
                if (hdr) chk("R1 header stamp", 64'(rd_data_o[39:0]), 64'(expq[0][39:0]));
                chk(hdr ? "R6 header word" : "R5/R6 channel word", 64'(rd_data_o), 64'(expq[0]));
                hdr = 1'b0;
                void'(expq.pop_front());
            end
            n++;
            tick();
        end
        chk("R8 all words delivered", 64'(expq.size()), 64'(0));
        rd_ready_i = 1'b0;
        @(negedge clk);
        chk("R8 rd_valid_o drops after last", 64'(rd_valid_o), 64'(0));
        reading = 1'b0;
        tick();
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            adc_v[c] = '0;
            thr_v[c] = '0;
        end
        repeat (3) begin
            @(negedge clk);
            chk("R12 outputs in reset", 64'({trig_ack_o, gate_o, sample_o, held_o, rd_valid_o}), 64'(0));
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R12 outputs after reset", 64'({trig_ack_o, gate_o, sample_o, held_o, rd_valid_o}), 64'(0));
        repeat (5) tick();

        // event 1: integrate, mixed suppression incl. equal-to-threshold
        integ_en_i   = 1'b1;
        gate_width_i = 8'd5;
        for (int c = 0; c < NCH; c++) begin
            adc_v[c] = VW'(100 + c * 37);
            thr_v[c] = (c % 2 == 0) ? VW'(50) : adc_v[c];
        end
        thr_v[15] = adc_v[15] - 1'b1;
        fire(1'b1);
        wait_held();
        decide(1'b1, 1'b0);
        read_event(0);

        // event 2: delay mode, width 0, all suppressed; early accept ignored (R11)
        wait_until(acc_m + MIN_GAP);
        integ_en_i   = 1'b0;
        gate_width_i = 8'd0;
        for (int c = 0; c < NCH; c++) thr_v[c] = 12'hFFF;
        fire(1'b1);
        accept_i = 1'b1;
        tick();
        accept_i = 1'b0;
        wait_held();
        repeat (3) tick();
        decide(1'b1, 1'b1);   // R9: discard wins
        repeat (4) tick();

        // R2: spacing one short, then exact
        integ_en_i   = 1'b1;
        gate_width_i = 8'd3;
        for (int c = 0; c < NCH; c++) begin
            adc_v[c] = 12'hFFF - VW'(c);
            thr_v[c] = '0;
        end
        wait_until(acc_m + MIN_GAP - 1);
        fire(1'b0);
        fire(1'b1);
        wait_held();
        wait_until(acc_m + MIN_GAP + 2);
        fire(1'b0);           // R10: busy in HOLD
        decide(1'b1, 1'b0);
        read_event(1);

        // event 4: discarded; event 5 shows block is idle again
        wait_until(acc_m + MIN_GAP);
        gate_width_i = 8'd1;
        for (int c = 0; c < NCH; c++) thr_v[c] = (c < 8) ? 12'hFFF : 12'd0;
        fire(1'b1);
        wait_held();
        decide(1'b0, 1'b1);   // R9
        wait_until(acc_m + MIN_GAP);
        integ_en_i   = 1'b0;
        gate_width_i = 8'd7;
        for (int c = 0; c < NCH; c++) adc_v[c] = VW'(c * 200 + 3);
        fire(1'b1);
        wait_held();
        decide(1'b1, 1'b0);
        read_event(1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule